// File: doc/BRIEF.md
# Sync timing reference comparator

This block watches a synchronised horizontal and vertical sync pair and takes four timing measurements: clocks per line, clocks per frame, lines per frame, and the width of the vertical sync pulse in clocks. It also works out the active polarity of each sync. Each result is compared against a programmed reference, and one mismatch flag is raised per measurement. Mode logic, such as a video front end's autodetect, reads the flags to decide whether the incoming timing still fits a known format.

The references use offset encodings. The line reference counts one short and the frame reference counts two short. The vertical-width reference also counts one short. The lines-per-frame reference is used as given. Tolerances are four-bit exponents n, and a measurement passes when it lies within plus or minus 2^n of its effective reference.

Two modes exist. In free-running mode the flags are refreshed at every frame and an activity bit flips on each refresh. In one-shot mode a start pulse arms a single full-frame measurement, and the flags then hold.

Top module: `sync_ref_cmp`

## Requirements
- R1: The line length is the number of clocks between consecutive hsync rising edges, taken from the last line that completed before the update. `mis_line_o` is 1 exactly when |line length − (`ref_line_clks_i`+1)| > 2^`tol_h_exp_i`.
- R2: The frame length is the number of clocks between consecutive vsync rising edges. `mis_frame_o` is 1 exactly when |frame length − (`ref_frame_clks_i`+2)| > 2^`tol_v_exp_i`.
- R3: The lines per frame is the number of hsync rising edges in the frame. `mis_lines_o` is 1 exactly when |lines − `ref_frame_lines_i`| > 2^`tol_l_exp_i`.
- R4: The vsync width is the number of frame clocks spent at the active level. `mis_vs_width_o` is 1 exactly when |width − (`ref_vs_width_i`+1)| > 2^`tol_v_exp_i`.
- R5: A sync is judged active high when it is high for fewer than half the clocks of its period, and active low otherwise. A reference bit of 1 means active high and 0 means active low. `mis_hs_pol_o` and `mis_vs_pol_o` are 1 when the judged polarity differs from the reference bit.
- R6: The mismatch flags change only at the clock edge that samples a vsync rising edge. Between such edges they hold, whatever the references do.
- R7: In free-running mode (`free_run_i`=1), every vsync rising edge after the first one since reset updates the flags. `activity_o` toggles on each such update.
- R8: In one-shot mode (`free_run_i`=0), a rising edge on `start_i` arms a measurement. The frame that begins at the next vsync rising edge is measured, and the flags update at the vsync rising edge that ends it. The flags then hold until the next start, and `activity_o` never changes in this mode.
- R9: After reset, all six mismatch flags and `activity_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Synchronised horizontal sync |
| vsync_i | input | 1 | Synchronised vertical sync |
| free_run_i | input | 1 | 1 selects free-running mode, 0 selects one-shot mode |
| start_i | input | 1 | A rising edge arms a one-shot measurement |
| ref_line_clks_i | input | W_CLK | Clocks-per-line reference, minus one |
| ref_frame_clks_i | input | W_CLK | Clocks-per-frame reference, minus two |
| ref_frame_lines_i | input | W_LN | Lines-per-frame reference |
| ref_vs_width_i | input | W_CLK | Vsync active width reference, minus one |
| ref_hs_pol_i | input | 1 | Expected hsync polarity (1 = active high) |
| ref_vs_pol_i | input | 1 | Expected vsync polarity (1 = active high) |
| tol_h_exp_i | input | 4 | Line tolerance exponent |
| tol_v_exp_i | input | 4 | Frame and vsync-width tolerance exponent |
| tol_l_exp_i | input | 4 | Lines-per-frame tolerance exponent |
| mis_line_o | output | 1 | Line length mismatch |
| mis_frame_o | output | 1 | Frame length mismatch |
| mis_lines_o | output | 1 | Lines-per-frame mismatch |
| mis_vs_width_o | output | 1 | Vsync width mismatch |
| mis_hs_pol_o | output | 1 | Hsync polarity mismatch |
| mis_vs_pol_o | output | 1 | Vsync polarity mismatch |
| activity_o | output | 1 | Toggles on each free-running update |

## Verification
A corrupted period or high-time counter shows up at the first vsync rising edge after the fault. The affected flag then disagrees with the arithmetic expectation for a reference offset by d, so a sweep of d across each tolerance edge exposes any off-by-one within one frame. A stuck or misrouted mode state shows within two to three frames, either as flags that fail to hold after a one-shot update or as an activity bit whose toggle count over four frame periods is not exactly four.

// File: rtl/sref_pkg.sv
package sref_pkg;
   localparam int unsigned TOL_EXP_W = 4;

   typedef enum logic [1:0] {
      OS_IDLE = 2'd0,
      OS_WAIT = 2'd1,
      OS_MEAS = 2'd2
   } os_state_e;
endpackage

// File: rtl/sref_period_meas.sv
// Period and high-time counters for one sync input, both bounded by rising edges.
module sref_period_meas #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sig_i,
   output logic         rise_o,
   output logic         armed_o,
   output logic [W-1:0] run_len_o,
   output logic [W-1:0] run_hi_o
);
   localparam logic [W-1:0] CNT_MAX = '1;
   localparam logic [W-1:0] CNT_ONE = W'(1);

   generate
      if (W < 2) begin : g_bad_width
         $error("sref_period_meas: W must be at least 2");
      end
   endgenerate

   logic         sig_q;
   logic [W-1:0] len_c;
   logic [W-1:0] hi_c;

   assign rise_o    = sig_i & ~sig_q;
   assign run_len_o = len_c;
   assign run_hi_o  = hi_c;

   // sig_q resets high so that a level already high at reset is not taken as an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_q   <= 1'b1;
         len_c   <= '0;
         hi_c    <= '0;
         armed_o <= 1'b0;
      end else begin
         sig_q <= sig_i;
         if (rise_o) begin
            len_c   <= CNT_ONE;
            hi_c    <= CNT_ONE;
            armed_o <= 1'b1;
         end else begin
            if (len_c != CNT_MAX) len_c <= len_c + CNT_ONE;
            if (sig_i && (hi_c != CNT_MAX)) hi_c <= hi_c + CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/sref_tol_cmp.sv
// Window compare: |meas - (ref + OFFSET)| > 2^exp raises mismatch.
module sref_tol_cmp #(
   parameter int unsigned W      = 24,
   parameter int unsigned OFFSET = 0,
   parameter int unsigned EXP_W  = 4
) (
   input  logic [W-1:0]     meas_i,
   input  logic [W-1:0]     ref_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             mismatch_o
);
   localparam int unsigned DW      = W + 2;
   localparam int unsigned MAX_EXP = (1 << EXP_W) - 1;

   generate
      if (OFFSET > 3) begin : g_bad_offset
         $error("sref_tol_cmp: OFFSET above 3 does not fit the guard bits");
      end
   endgenerate

   logic [DW-1:0] eff;
   logic [DW-1:0] meas_ext;
   logic [DW-1:0] diff;
   logic [DW-1:0] thr;

   assign eff      = {2'b00, ref_i} + DW'(OFFSET);
   assign meas_ext = {2'b00, meas_i};
   assign diff     = (meas_ext >= eff) ? (meas_ext - eff) : (eff - meas_ext);

   generate
      if (DW > MAX_EXP) begin : g_thr_direct
         assign thr = DW'(1) << exp_i;
      end else begin : g_thr_sat
         assign thr = (32'(exp_i) >= DW) ? '1 : (DW'(1) << exp_i);
      end
   endgenerate

   assign mismatch_o = diff > thr;
endmodule

// File: rtl/sync_ref_cmp.sv
module sync_ref_cmp #(
   parameter int unsigned W_CLK = 24,
   parameter int unsigned W_LN  = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          hsync_i,
   input  logic                          vsync_i,
   input  logic                          free_run_i,
   input  logic                          start_i,
   input  logic [W_CLK-1:0]              ref_line_clks_i,
   input  logic [W_CLK-1:0]              ref_frame_clks_i,
   input  logic [W_LN-1:0]               ref_frame_lines_i,
   input  logic [W_CLK-1:0]              ref_vs_width_i,
   input  logic                          ref_hs_pol_i,
   input  logic                          ref_vs_pol_i,
   input  logic [sref_pkg::TOL_EXP_W-1:0] tol_h_exp_i,
   input  logic [sref_pkg::TOL_EXP_W-1:0] tol_v_exp_i,
   input  logic [sref_pkg::TOL_EXP_W-1:0] tol_l_exp_i,
   output logic                          mis_line_o,
   output logic                          mis_frame_o,
   output logic                          mis_lines_o,
   output logic                          mis_vs_width_o,
   output logic                          mis_hs_pol_o,
   output logic                          mis_vs_pol_o,
   output logic                          activity_o
);
   import sref_pkg::*;

   localparam logic [W_LN-1:0] LN_MAX = '1;
   localparam logic [W_LN-1:0] LN_ONE = W_LN'(1);

   generate
      if (W_LN > W_CLK) begin : g_bad_ln
         $error("sync_ref_cmp: W_LN must not exceed W_CLK");
      end
      if (W_CLK < 4) begin : g_bad_clk
         $error("sync_ref_cmp: W_CLK must be at least 4");
      end
   endgenerate

   // ---------------- edge and period measurement ----------------
   logic             hs_rise, hs_armed, vs_rise, vs_armed;
   logic [W_CLK-1:0] h_run_len, h_run_hi, v_run_len, v_run_hi;

   sref_period_meas #(.W(W_CLK)) u_hmeas (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_i    (hsync_i),
      .rise_o   (hs_rise),
      .armed_o  (hs_armed),
      .run_len_o(h_run_len),
      .run_hi_o (h_run_hi)
   );

   sref_period_meas #(.W(W_CLK)) u_vmeas (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_i    (vsync_i),
      .rise_o   (vs_rise),
      .armed_o  (vs_armed),
      .run_len_o(v_run_len),
      .run_hi_o (v_run_hi)
   );

   // last completed line
   logic [W_CLK-1:0] h_len_q, h_hi_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_len_q <= '0;
         h_hi_q  <= '0;
      end else if (hs_rise && hs_armed) begin
         h_len_q <= h_run_len;
         h_hi_q  <= h_run_hi;
      end
   end

   // hsync edges within the running frame
   logic [W_LN-1:0] line_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt <= '0;
      end else if (vs_rise) begin
         line_cnt <= hs_rise ? LN_ONE : '0;
      end else if (hs_rise && (line_cnt != LN_MAX)) begin
         line_cnt <= line_cnt + LN_ONE;
      end
   end

   // ---------------- polarity and width ----------------
   logic             h_act_high, v_act_high;
   logic [W_CLK-1:0] v_width;

   assign h_act_high = {h_hi_q, 1'b0} < {1'b0, h_len_q};
   assign v_act_high = {v_run_hi, 1'b0} < {1'b0, v_run_len};
   assign v_width    = v_act_high ? v_run_hi : (v_run_len - v_run_hi);

   // ---------------- window comparators ----------------
   logic c_line, c_frame, c_lines, c_vwid;

   sref_tol_cmp #(.W(W_CLK), .OFFSET(1), .EXP_W(TOL_EXP_W)) u_cmp_line (
      .meas_i    (h_len_q),
      .ref_i     (ref_line_clks_i),
      .exp_i     (tol_h_exp_i),
      .mismatch_o(c_line)
   );

   sref_tol_cmp #(.W(W_CLK), .OFFSET(2), .EXP_W(TOL_EXP_W)) u_cmp_frame (
      .meas_i    (v_run_len),
      .ref_i     (ref_frame_clks_i),
      .exp_i     (tol_v_exp_i),
      .mismatch_o(c_frame)
   );

   sref_tol_cmp #(.W(W_LN), .OFFSET(0), .EXP_W(TOL_EXP_W)) u_cmp_lines (
      .meas_i    (line_cnt),
      .ref_i     (ref_frame_lines_i),
      .exp_i     (tol_l_exp_i),
      .mismatch_o(c_lines)
   );

   sref_tol_cmp #(.W(W_CLK), .OFFSET(1), .EXP_W(TOL_EXP_W)) u_cmp_vwid (
      .meas_i    (v_width),
      .ref_i     (ref_vs_width_i),
      .exp_i     (tol_v_exp_i),
      .mismatch_o(c_vwid)
   );

   // ---------------- mode control ----------------
   os_state_e os_state;
   logic      start_q;
   logic      start_rise;
   logic      update;

   assign start_rise = start_i & ~start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         os_state <= OS_IDLE;
         start_q  <= 1'b0;
      end else begin
         start_q <= start_i;
         if (free_run_i) begin
            os_state <= OS_IDLE;
         end else if (start_rise) begin
            os_state <= OS_WAIT;
         end else if (vs_rise) begin
            case (os_state)
               OS_WAIT: os_state <= OS_MEAS;
               OS_MEAS: os_state <= OS_IDLE;
               default: os_state <= OS_IDLE;
            endcase
         end
      end
   end

   assign update = vs_rise & vs_armed & (free_run_i | (os_state == OS_MEAS));

   // ---------------- status ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mis_line_o     <= 1'b0;
         mis_frame_o    <= 1'b0;
         mis_lines_o    <= 1'b0;
         mis_vs_width_o <= 1'b0;
         mis_hs_pol_o   <= 1'b0;
         mis_vs_pol_o   <= 1'b0;
         activity_o     <= 1'b0;
      end else if (update) begin
         mis_line_o     <= c_line;
         mis_frame_o    <= c_frame;
         mis_lines_o    <= c_lines;
         mis_vs_width_o <= c_vwid;
         mis_hs_pol_o   <= h_act_high ^ ref_hs_pol_i;
         mis_vs_pol_o   <= v_act_high ^ ref_vs_pol_i;
         if (free_run_i) activity_o <= ~activity_o;
      end
   end
endmodule

// File: rtl/sref_cmp_chk.sv
module sref_cmp_chk #(
   parameter int unsigned W = 24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         hsync_i,
   input logic         vsync_i,
   input logic         free_run_i,
   input logic [5:0]   flags_i,
   input logic         activity_i,
   input logic [W-1:0] h_len_i
);
   logic vs_q, hs_q, v_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q   <= 1'b1;
         hs_q   <= 1'b1;
         v_seen <= 1'b0;
      end else begin
         vs_q <= vsync_i;
         hs_q <= hsync_i;
         if (vsync_i && !vs_q) v_seen <= 1'b1;
      end
   end

   // R6: flags move only at a sampled vsync rising edge
   p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(vsync_i && !vs_q) |=> $stable(flags_i));

   // R8: one-shot mode never changes activity
   p_act_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !free_run_i |=> $stable(activity_i));

   // R7: activity is quiet away from vsync rising edges
   p_act_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(vsync_i && !vs_q) |=> $stable(activity_i));

   // R7: every armed free-running edge toggles activity
   p_act_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (free_run_i && vsync_i && !vs_q && v_seen) |=> (activity_i != $past(activity_i)));

   // R1: captured line length holds between hsync rising edges
   p_line_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(hsync_i && !hs_q) |=> $stable(h_len_i));
endmodule

bind sync_ref_cmp sref_cmp_chk #(.W(W_CLK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hsync_i   (hsync_i),
   .vsync_i   (vsync_i),
   .free_run_i(free_run_i),
   .flags_i   ({mis_line_o, mis_frame_o, mis_lines_o, mis_vs_width_o, mis_hs_pol_o, mis_vs_pol_o}),
   .activity_i(activity_o),
   .h_len_i   (h_len_q)
);

// File: tb/sync_ref_cmp_tb.sv
`timescale 1ns/1ps
module sync_ref_cmp_tb;
   localparam int W_CLK = 24;
   localparam int W_LN  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync = 1'b0, vsync = 1'b0;
   logic free_run = 1'b1, start = 1'b0;
   logic [W_CLK-1:0] r_line = '0, r_frame = '0, r_vwid = '0;
   logic [W_LN-1:0]  r_lines = '0;
   logic r_hpol = 1'b0, r_vpol = 1'b0;
   logic [3:0] t_h = '0, t_v = '0, t_l = '0;
   logic m_line, m_frame, m_lines, m_vwid, m_hpol, m_vpol, act;

   always #2 clk = ~clk;

   sync_ref_cmp #(.W_CLK(W_CLK), .W_LN(W_LN)) u_dut (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .free_run_i(free_run), .start_i(start),
      .ref_line_clks_i(r_line), .ref_frame_clks_i(r_frame),
      .ref_frame_lines_i(r_lines), .ref_vs_width_i(r_vwid),
      .ref_hs_pol_i(r_hpol), .ref_vs_pol_i(r_vpol),
      .tol_h_exp_i(t_h), .tol_v_exp_i(t_v), .tol_l_exp_i(t_l),
      .mis_line_o(m_line), .mis_frame_o(m_frame), .mis_lines_o(m_lines),
      .mis_vs_width_o(m_vwid), .mis_hs_pol_o(m_hpol), .mis_vs_pol_o(m_vpol),
      .activity_o(act)
   );

   // sync generator: L clocks per line, N lines, hsync active for HW clocks, vsync for VW lines
   int L = 12, N = 6, HW = 3, VW = 1;
   logic HP = 1'b1, VP = 1'b1;
   int gx = 0, gy = 0;
   logic gen_restart = 1'b0;
   event frame_evt;

   always @(negedge clk) begin
      if (gen_restart) begin
         gx = 0; gy = 0; gen_restart = 1'b0;
      end
      if (gx == 0 && gy == 0) -> frame_evt;
      hsync <= HP ? (gx < HW) : !(gx < HW);
      vsync <= VP ? (gy < VW) : !(gy < VW);
      gx = gx + 1;
      if (gx >= L) begin
         gx = 0;
         gy = (gy + 1 >= N) ? 0 : gy + 1;
      end
   end

   int n_chk = 0, n_bad = 0;
   logic done = 1'b0;

   task automatic chk(input string req, input logic actual, input logic expected);
      n_chk++;
      if (actual !== expected) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b", req, actual, expected);
      end
   endtask

   task automatic wait_frames(input int k);
      repeat (k * L * N + 5) @(posedge clk);
      #1;
   endtask

   task automatic set_cfg(input int l, input int n, input int hw, input int vw,
                          input logic hp, input logic vp);
      @(posedge clk);
      L = l; N = n; HW = hw; VW = vw; HP = hp; VP = vp;
      gen_restart = 1'b1;
   endtask

   task automatic exact_refs();
      r_line  = W_CLK'(L - 1);
      r_frame = W_CLK'(L * N - 2);
      r_lines = W_LN'(N);
      r_vwid  = W_CLK'(VW * L - 1);
      r_hpol  = HP; r_vpol = VP;
      t_h = 4'd0; t_v = 4'd0; t_l = 4'd0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (5) @(posedge clk);
      #1;
      chk("R9 mis_line", m_line, 1'b0);   chk("R9 mis_frame", m_frame, 1'b0);
      chk("R9 mis_lines", m_lines, 1'b0); chk("R9 mis_vs_width", m_vwid, 1'b0);
      chk("R9 mis_hs_pol", m_hpol, 1'b0); chk("R9 mis_vs_pol", m_vpol, 1'b0);
      chk("R9 activity", act, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // exact references, free-running
      set_cfg(12, 6, 3, 1, 1'b1, 1'b1);
      exact_refs();
      wait_frames(3);
      chk("R1 exact", m_line, 1'b0);  chk("R2 exact", m_frame, 1'b0);
      chk("R3 exact", m_lines, 1'b0); chk("R4 exact", m_vwid, 1'b0);
      chk("R5 hpol exact", m_hpol, 1'b0); chk("R5 vpol exact", m_vpol, 1'b0);

      // tolerance sweeps: R1 line, R2 frame, R3 lines, R4 vsync width
      for (int k = 0; k < 4; k++) begin
         for (int e = 0; e < 3; e++) begin
            for (int d = -5; d <= 5; d++) begin
               logic expm;
               logic got;
               string tag;
               exact_refs();
               expm = ((d < 0) ? -d : d) > (1 << e);
               case (k)
                  0: begin r_line  = W_CLK'(L - 1 + d);         t_h = 4'(e); end
                  1: begin r_frame = W_CLK'(L * N - 2 + d);     t_v = 4'(e); end
                  2: begin r_lines = W_LN'(N + d);              t_l = 4'(e); end
                  default: begin r_vwid = W_CLK'(VW * L - 1 + d); t_v = 4'(e); end
               endcase
               wait_frames(2);
               case (k)
                  0: begin got = m_line;  tag = "R1 window"; end
                  1: begin got = m_frame; tag = "R2 window"; end
                  2: begin got = m_lines; tag = "R3 window"; end
                  default: begin got = m_vwid; tag = "R4 window"; end
               endcase
               chk(tag, got, expm);
            end
         end
      end

      // R5: polarity grid on a second timing
      for (int hp = 0; hp < 2; hp++) begin
         for (int vp = 0; vp < 2; vp++) begin
            set_cfg(16, 7, 4, 2, hp[0], vp[0]);
            exact_refs();
            wait_frames(3);
            chk("R5 hpol match", m_hpol, 1'b0);
            chk("R5 vpol match", m_vpol, 1'b0);
            chk("R4 width other pol", m_vwid, 1'b0);
            chk("R3 lines other pol", m_lines, 1'b0);
            chk("R1 line other pol", m_line, 1'b0);
            chk("R2 frame other pol", m_frame, 1'b0);
            r_hpol = !hp[0]; r_vpol = !vp[0];
            wait_frames(2);
            chk("R5 hpol mismatch", m_hpol, 1'b1);
            chk("R5 vpol mismatch", m_vpol, 1'b1);
         end
      end

      // R7: four toggles in four frame periods
      set_cfg(12, 6, 3, 1, 1'b1, 1'b1);
      exact_refs();
      wait_frames(3);
      begin
         int toggles = 0;
         logic prev = act;
         for (int c = 0; c < 4 * L * N; c++) begin
            @(posedge clk); #1;
            if (act != prev) toggles++;
            prev = act;
         end
         chk("R7 four toggles", (toggles == 4), 1'b1);
      end

      // R6: a bad reference mid-frame does not reach the flag before the next vsync edge
      @(frame_evt);
      repeat (3) @(posedge clk);
      r_line = W_CLK'(L + 8);
      repeat (L * N / 2) @(posedge clk);
      #1;
      chk("R6 held mid-frame", m_line, 1'b0);
      repeat (L * N) @(posedge clk);
      #1;
      chk("R6 updated at edge", m_line, 1'b1);
      exact_refs();
      wait_frames(2);

      // R8: one-shot mode
      free_run = 1'b0;
      r_lines = W_LN'(N + 5);
      begin
         logic a0 = act;
         wait_frames(4);
         chk("R8 held before start", m_lines, 1'b0);
         chk("R8 activity still", act, a0);
         pulse_start();
         wait_frames(3);
         chk("R8 one-shot result", m_lines, 1'b1);
         exact_refs();
         wait_frames(3);
         chk("R8 result held", m_lines, 1'b1);
         pulse_start();
         wait_frames(3);
         chk("R8 second shot", m_lines, 1'b0);
         chk("R8 activity unchanged", act, a0);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule